// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This combinational block settles the outcome of a double-precision fused multiply-add, or of its multiply-subtract variant, whenever an operand is a NaN, an infinity or a zero. The operation is z plus the product x·y. When a negate flag is set, the product is subtracted instead.

Operand classification happens upstream, so the block receives a three-bit class code and a sign for each of z, x and y. It also receives the negate flag and a bit that says the rounding mode is toward minus infinity. It answers with a one-hot result selector, the sign of the result, a one-hot operand pointer used when a signalling NaN must be quieted, and the invalid-operation flag.

A downstream multiplexer uses the selector to choose among several results: one of the operands, a quieted NaN, the default NaN, a signed infinity or a signed zero. The selector can also tell the arithmetic datapath to compute the result.

Top module: `fma_special_resolver`

## Requirements
- R1: Class codes are 0 zero, 1 normal, 2 denormal, 3 infinity, 4 quiet NaN and 5 signalling NaN. When several operands are NaN, the winner is chosen in this order: signalling z, signalling x, signalling y, quiet z, quiet x, quiet y.
- R2: When the winning NaN is signalling, the outputs are as follows:
  - the selector is the quieted-NaN code;
  - `nan_src` is one-hot on that operand (bit 0 z, bit 1 x, bit 2 y);
  - the sign is that operand's sign;
  - `invalid` is high.
- R3: When the winning NaN is quiet, the selector passes that operand through. The sign is that operand's sign, `invalid` is low and `nan_src` is zero.
- R4: With no NaN present, an infinity times a zero (in either order) selects the default NaN with sign 0 and raises `invalid`.
- R5: With no NaN present, an infinite product added to an infinite z whose sign differs from the effective product sign selects the default NaN with sign 0 and raises `invalid`. The effective product sign is x sign XOR y sign XOR the negate flag.
- R6: In all other cases, an infinite product selects infinity carrying the effective product sign.
- R7: A zero product with an infinite z selects infinity with z's sign. A zero product with a nonzero finite z passes z through with z's sign.
- R8: A zero product with a zero z behaves as follows:
  - if z's sign equals the effective product sign, z is passed through;
  - otherwise the result is zero, with a sign equal to the round-toward-minus-infinity bit.
- R9: A finite nonzero product with an infinite z selects infinity with z's sign.
- R10: When none of the above applies, the selector is continue, the sign is the effective product sign and `invalid` is low.
- R11: The selector is always exactly one-hot, with bit order 0 continue, 1 pass z, 2 pass x, 3 pass y, 4 quieted NaN, 5 default NaN, 6 infinity and 7 zero. `nan_src` is zero unless the quieted-NaN bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| z_cls | input | 3 | class code of the addend z |
| z_sgn | input | 1 | sign of z |
| x_cls | input | 3 | class code of multiplicand x |
| x_sgn | input | 1 | sign of x |
| y_cls | input | 3 | class code of multiplier y |
| y_sgn | input | 1 | sign of y |
| neg_prod | input | 1 | subtract the product instead of adding it |
| rnd_down | input | 1 | rounding mode is toward minus infinity |
| res_sel | output | 8 | one-hot result selector |
| res_sgn | output | 1 | sign of the selected result |
| nan_src | output | 3 | operand whose NaN is quieted (z, x, y) |
| invalid | output | 1 | invalid-operation exception |

## Verification
The embedded assertions take for granted that every class input carries one of the six defined codes. Codes 6 and 7 never reach the block, and an unused code would simply be treated as a finite nonzero value. The stimulus draws each class as a random value modulo six, so the random traffic never leaves the legal range. The directed cases also stay within that range. Those directed cases target the NaN priority ties, infinities of opposite signs under both negate settings, and the signed-zero cancellation under both rounding settings.

// File: rtl/fmasr_pkg.sv
`timescale 1ns/1ps
package fmasr_pkg;
   // operand class codes
   localparam int CLS_ZERO  = 0;
   localparam int CLS_NORM  = 1;
   localparam int CLS_DNORM = 2;
   localparam int CLS_INF   = 3;
   localparam int CLS_QNAN  = 4;
   localparam int CLS_SNAN  = 5;

   // result selector bit positions
   localparam int SEL_CONT   = 0;
   localparam int SEL_PASS_Z = 1;
   localparam int SEL_PASS_X = 2;
   localparam int SEL_PASS_Y = 3;
   localparam int SEL_QUIET  = 4;
   localparam int SEL_DNAN   = 5;
   localparam int SEL_INF    = 6;
   localparam int SEL_ZERO   = 7;
   localparam int SEL_COUNT  = 8;
endpackage

// File: rtl/fmasr_nan_pick.sv
`timescale 1ns/1ps
module fmasr_nan_pick
   import fmasr_pkg::*;
#(
   parameter int NUM_OPS = 3,
   parameter int CLS_W   = 3
) (
   input  logic [NUM_OPS*CLS_W-1:0] cls_vec,
   input  logic [NUM_OPS-1:0]       sgn_vec,
   output logic                     hit,
   output logic                     is_sig,
   output logic [NUM_OPS-1:0]       pick,
   output logic                     pick_sgn
);
   logic [NUM_OPS-1:0] snan;
   logic [NUM_OPS-1:0] qnan;

   // per-operand NaN detection; operand 0 has the highest priority
   for (genvar i = 0; i < NUM_OPS; i++) begin : g_det
      assign snan[i] = (cls_vec[i*CLS_W +: CLS_W] == CLS_W'(CLS_SNAN));
      assign qnan[i] = (cls_vec[i*CLS_W +: CLS_W] == CLS_W'(CLS_QNAN));
   end

   always_comb begin
      hit      = 1'b0;
      is_sig   = 1'b0;
      pick     = '0;
      pick_sgn = 1'b0;
      for (int i = 0; i < NUM_OPS; i++) begin
         if (!hit && snan[i]) begin
            hit      = 1'b1;
            is_sig   = 1'b1;
            pick[i]  = 1'b1;
            pick_sgn = sgn_vec[i];
         end
      end
      for (int i = 0; i < NUM_OPS; i++) begin
         if (!hit && qnan[i]) begin
            hit      = 1'b1;
            pick[i]  = 1'b1;
            pick_sgn = sgn_vec[i];
         end
      end
   end

   always_comb begin
      // R1: exactly one winner whenever any NaN is present
      a_r1_one_winner: assert ($countones(pick) == ((|(snan | qnan)) ? 1 : 0));
      // R1: a signalling NaN anywhere beats every quiet NaN
      a_r1_sig_first: assert (!(|snan) || (is_sig && |(pick & snan)));
   end
endmodule

// File: rtl/fmasr_inf_zero.sv
`timescale 1ns/1ps
module fmasr_inf_zero
   import fmasr_pkg::*;
#(
   parameter int   CLS_W    = 3,
   parameter int   SEL_W    = 8,
   parameter logic DNAN_SGN = 1'b0
) (
   input  logic [CLS_W-1:0] z_cls,
   input  logic             z_sgn,
   input  logic [CLS_W-1:0] x_cls,
   input  logic             x_sgn,
   input  logic [CLS_W-1:0] y_cls,
   input  logic             y_sgn,
   input  logic             neg_prod,
   input  logic             rnd_down,
   output logic [SEL_W-1:0] sel,
   output logic             sgn,
   output logic             inv
);
   logic prod_sgn;
   logic x_inf, y_inf, x_zero, y_zero, z_inf, z_zero;

   assign prod_sgn = x_sgn ^ y_sgn ^ neg_prod;
   assign x_inf    = (x_cls == CLS_W'(CLS_INF));
   assign y_inf    = (y_cls == CLS_W'(CLS_INF));
   assign x_zero   = (x_cls == CLS_W'(CLS_ZERO));
   assign y_zero   = (y_cls == CLS_W'(CLS_ZERO));
   assign z_inf    = (z_cls == CLS_W'(CLS_INF));
   assign z_zero   = (z_cls == CLS_W'(CLS_ZERO));

   always_comb begin
      sel           = '0;
      sel[SEL_CONT] = 1'b1;
      sgn           = prod_sgn;
      inv           = 1'b0;
      if ((x_inf && y_zero) || (x_zero && y_inf)) begin
         sel           = '0;
         sel[SEL_DNAN] = 1'b1;
         sgn           = DNAN_SGN;
         inv           = 1'b1;
      end else if (x_inf || y_inf) begin
         sel = '0;
         if (z_inf && (z_sgn != prod_sgn)) begin
            sel[SEL_DNAN] = 1'b1;
            sgn           = DNAN_SGN;
            inv           = 1'b1;
         end else begin
            sel[SEL_INF] = 1'b1;
         end
      end else if (x_zero || y_zero) begin
         sel = '0;
         sgn = z_sgn;
         if (z_inf) begin
            sel[SEL_INF] = 1'b1;
         end else if (z_zero && (z_sgn != prod_sgn)) begin
            sel[SEL_ZERO] = 1'b1;
            sgn           = rnd_down;
         end else begin
            sel[SEL_PASS_Z] = 1'b1;
         end
      end else if (z_inf) begin
         sel          = '0;
         sel[SEL_INF] = 1'b1;
         sgn          = z_sgn;
      end
   end

   always_comb begin
      // R4: infinity times zero is always invalid
      a_r4_inf_times_zero: assert (!((x_inf && y_zero) || (x_zero && y_inf)) ||
                                   (inv && sel[SEL_DNAN]));
      // R8: cancelling zeros take their sign from the rounding mode
      a_r8_zero_sign: assert (!sel[SEL_ZERO] || (sgn == rnd_down && z_zero));
      // R6: an infinite result from an infinite product has the product sign
      a_r6_inf_sign: assert (!(sel[SEL_INF] && (x_inf || y_inf)) || (sgn == prod_sgn));
   end
endmodule

// File: rtl/fma_special_resolver.sv
`timescale 1ns/1ps
module fma_special_resolver
   import fmasr_pkg::*;
#(
   parameter int   CLS_W    = 3,
   parameter int   SEL_W    = 8,
   parameter logic DNAN_SGN = 1'b0
) (
   input  logic [CLS_W-1:0] z_cls,
   input  logic             z_sgn,
   input  logic [CLS_W-1:0] x_cls,
   input  logic             x_sgn,
   input  logic [CLS_W-1:0] y_cls,
   input  logic             y_sgn,
   input  logic             neg_prod,
   input  logic             rnd_down,
   output logic [SEL_W-1:0] res_sel,
   output logic             res_sgn,
   output logic [2:0]       nan_src,
   output logic             invalid
);
   localparam int NUM_OPS = 3;

   if (CLS_W < 3) begin : g_bad_cls
      $error("CLS_W must hold six class codes");
   end
   if (SEL_W != SEL_COUNT) begin : g_bad_sel
      $error("SEL_W must equal the selector count");
   end

   logic               nan_hit, nan_sig, nan_sgn;
   logic [NUM_OPS-1:0] nan_pick;
   logic [SEL_W-1:0]   iz_sel;
   logic               iz_sgn, iz_inv;

   fmasr_nan_pick #(.NUM_OPS(NUM_OPS), .CLS_W(CLS_W)) u_nan (
      .cls_vec  ({y_cls, x_cls, z_cls}),
      .sgn_vec  ({y_sgn, x_sgn, z_sgn}),
      .hit      (nan_hit),
      .is_sig   (nan_sig),
      .pick     (nan_pick),
      .pick_sgn (nan_sgn)
   );

   fmasr_inf_zero #(.CLS_W(CLS_W), .SEL_W(SEL_W), .DNAN_SGN(DNAN_SGN)) u_iz (
      .z_cls, .z_sgn, .x_cls, .x_sgn, .y_cls, .y_sgn,
      .neg_prod, .rnd_down,
      .sel (iz_sel),
      .sgn (iz_sgn),
      .inv (iz_inv)
   );

   always_comb begin
      res_sel = iz_sel;
      res_sgn = iz_sgn;
      invalid = iz_inv;
      nan_src = '0;
      if (nan_hit) begin
         res_sel = '0;
         res_sgn = nan_sgn;
         if (nan_sig) begin
            res_sel[SEL_QUIET] = 1'b1;
            nan_src            = nan_pick;
            invalid            = 1'b1;
         end else begin
            res_sel[SEL_PASS_Z +: NUM_OPS] = nan_pick;
            invalid                        = 1'b0;
         end
      end
   end

   logic any_snan;
   assign any_snan = (z_cls == CLS_W'(CLS_SNAN)) || (x_cls == CLS_W'(CLS_SNAN)) ||
                     (y_cls == CLS_W'(CLS_SNAN));

   always_comb begin
      // R11: selector is one-hot
      a_r11_sel_onehot: assert ($countones(res_sel) == 1);
      // R11: operand pointer only with the quieted-NaN selection
      a_r11_src_gated: assert ((nan_src == '0) || (res_sel[SEL_QUIET] && $countones(nan_src) == 1));
      // R2: any signalling NaN forces quieting and invalid
      a_r2_snan_invalid: assert (!any_snan || (invalid && res_sel[SEL_QUIET]));
      // R10: continuing to the datapath never raises invalid
      a_r10_cont_clean: assert (!res_sel[SEL_CONT] || !invalid);
   end
endmodule

// File: tb/fma_special_resolver_bench.sv
`timescale 1ns/1ps
module fma_special_resolver_bench;
   logic clk = 1'b0;
   always #4 clk = ~clk;  // 125 MHz

   logic [2:0] z_cls = '0, x_cls = '0, y_cls = '0;
   logic       z_sgn = 0, x_sgn = 0, y_sgn = 0, neg_prod = 0, rnd_down = 0;
   logic [7:0] res_sel;
   logic       res_sgn, invalid;
   logic [2:0] nan_src;

   int total = 0, bad = 0;
   bit done = 0;

   fma_special_resolver u_fma_special_resolver (
      .z_cls, .z_sgn, .x_cls, .x_sgn, .y_cls, .y_sgn,
      .neg_prod, .rnd_down, .res_sel, .res_sgn, .nan_src, .invalid
   );

   // independent reference model written from the requirements
   task automatic model(input logic [2:0] zc, xc, yc, input logic zs, xs, ys, ng, rd,
                        output logic [7:0] s, output logic sg, output logic iv,
                        output logic [2:0] src, output string tag);
      logic [2:0] c[3];
      logic       g[3];
      logic       ps;
      c[0] = zc; c[1] = xc; c[2] = yc;
      g[0] = zs; g[1] = xs; g[2] = ys;
      ps = xs ^ ys ^ ng;
      s = 8'h00; sg = 1'b0; iv = 1'b0; src = 3'b000;
      for (int k = 0; k < 3; k++) if (c[k] == 3'd5) begin
         s = 8'h10; sg = g[k]; iv = 1'b1; src = 3'(1 << k); tag = "R2"; return;
      end
      for (int k = 0; k < 3; k++) if (c[k] == 3'd4) begin
         s = 8'(2 << k); sg = g[k]; tag = "R3"; return;
      end
      if ((xc == 3'd3 && yc == 3'd0) || (xc == 3'd0 && yc == 3'd3)) begin
         s = 8'h20; iv = 1'b1; tag = "R4"; return;
      end
      if (xc == 3'd3 || yc == 3'd3) begin
         if (zc == 3'd3 && zs != ps) begin s = 8'h20; iv = 1'b1; tag = "R5"; return; end
         s = 8'h40; sg = ps; tag = "R6"; return;
      end
      if (xc == 3'd0 || yc == 3'd0) begin
         if (zc == 3'd3) begin s = 8'h40; sg = zs; tag = "R7"; return; end
         if (zc == 3'd0) begin
            tag = "R8";
            if (zs == ps) begin s = 8'h02; sg = zs; end
            else begin s = 8'h80; sg = rd; end
            return;
         end
         s = 8'h02; sg = zs; tag = "R7"; return;
      end
      if (zc == 3'd3) begin s = 8'h40; sg = zs; tag = "R9"; return; end
      s = 8'h01; sg = ps; tag = "R10";
   endtask

   task automatic run(input logic [2:0] zc, xc, yc, input logic zs, xs, ys, ng, rd);
      logic [7:0] es; logic eg, ei; logic [2:0] esrc; string tag;
      @(negedge clk);
      z_cls = zc; x_cls = xc; y_cls = yc;
      z_sgn = zs; x_sgn = xs; y_sgn = ys; neg_prod = ng; rnd_down = rd;
      #1;
      model(zc, xc, yc, zs, xs, ys, ng, rd, es, eg, ei, esrc, tag);
      total++;
      if ({res_sel, res_sgn, invalid, nan_src} !== {es, eg, ei, esrc}) begin
         bad++;
         $display("FAIL %s/R11 in z=%0d x=%0d y=%0d sg=%b%b%b n=%b r=%b: got sel=%h s=%b i=%b src=%b exp sel=%h s=%b i=%b src=%b",
                  tag, zc, xc, yc, zs, xs, ys, ng, rd,
                  res_sel, res_sgn, invalid, nan_src, es, eg, ei, esrc);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (2) @(posedge clk);
      // all-zero start state: zero product, zero z, same sign -> pass z (R8)
      run(0, 0, 0, 0, 0, 0, 0, 0);
      // R1 priority ties
      run(5, 5, 5, 1, 0, 0, 0, 0);  // R1 z signalling wins
      run(4, 5, 5, 0, 1, 0, 0, 0);  // R1 signalling x beats quiet z
      run(4, 4, 5, 0, 0, 1, 0, 0);  // R2 signalling y
      run(1, 4, 4, 0, 1, 0, 0, 0);  // R3 quiet x beats quiet y
      run(4, 3, 0, 1, 0, 0, 0, 0);  // R3 quiet z despite inf*zero
      // R4 both orders
      run(1, 3, 0, 0, 1, 1, 0, 0);
      run(3, 0, 3, 1, 0, 0, 1, 1);
      // R5 / R6 with both negate settings
      run(3, 3, 1, 1, 0, 0, 0, 0);  // R5 +prod vs -inf
      run(3, 3, 1, 0, 0, 0, 1, 0);  // R5 negated prod -inf vs +inf
      run(3, 1, 3, 1, 0, 0, 1, 0);  // R6 matching signs -> -inf
      run(2, 3, 3, 0, 1, 0, 0, 0);  // R6 -inf
      // R7, R8, R9, R10
      run(3, 0, 1, 1, 0, 0, 0, 0);  // R7 inf z
      run(2, 1, 0, 1, 0, 1, 0, 0);  // R7 pass z
      run(0, 0, 1, 0, 1, 0, 0, 0);  // R8 cancel, round-nearest -> +0
      run(0, 0, 1, 0, 1, 0, 0, 1);  // R8 cancel, round-down -> -0
      run(0, 1, 0, 1, 0, 0, 1, 0);  // R8 negated agree -> pass z
      run(3, 2, 1, 1, 0, 0, 0, 0);  // R9
      run(0, 2, 2, 0, 1, 0, 1, 0);  // R10
      for (int n = 0; n < 4000; n++) begin
         run(3'($urandom % 6), 3'($urandom % 6), 3'($urandom % 6),
             1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule